// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 38-bit physical address by reading two page table entries from memory. The upper ten bits of the virtual address select an entry in a first-level table. The base of that table is held in a root register that only privileged code may load. The frame field of that entry locates a second-level table. The next ten bits select the leaf entry in that table. The leaf frame, joined with the untouched 12-bit page offset, forms the physical address.

Each request carries an access type: read, write or instruction fetch. The walker faults instead of answering in two cases: the first-level entry has all three permission flags cleared, or the leaf entry lacks the flag that matches the access type. Entries are 32 bits wide. Bits [31:6] hold the frame number, bit 0 is read, bit 1 is write, bit 2 is execute, and bits [5:3] are reserved and never grant anything. Memory is reached through a request strobe with an address and a later response strobe with data. Only one walk runs at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `memReqValid`, `doneValid` and `faultValid` are all low.
- R2: The first read of a walk is a one-cycle `memReqValid` pulse at address {root frame, vaddr[31:22], 2'b00}.
- R3: A first-level entry with bits [2:0] all zero ends the walk with a fault after only one memory read, whatever its reserved bits hold.
- R4: The second read is a one-cycle pulse at address {first-level entry[31:6], vaddr[21:12], 2'b00}.
- R5: The leaf check uses the flag that matches `reqAccess`: code 0 (read) needs bit 0, code 1 (write) needs bit 1, code 2 (fetch) needs bit 2. Code 3 always faults. A missing flag gives a fault.
- R6: A successful walk gives `donePaddr` = {leaf entry[31:6], vaddr[11:0]} in the cycle where `doneValid` is high.
- R7: `doneValid` or `faultValid` is high for exactly one cycle, and never both at once. `busy` is high from the cycle after a request is accepted until the walker is back in idle.
- R8: `reqValid` is ignored while `busy` is high. A stray request neither changes the ongoing result nor starts a further walk.
- R9: The root register loads `rootWrData` only on a cycle where both `rootWrEn` and `privMode` are high. A write without privilege leaves it unchanged.
- R10: The walker waits any number of cycles for `memRspValid` after each read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| privMode | input | 1 | High when the writer is in privileged mode |
| rootWrEn | input | 1 | Root register write strobe |
| rootWrData | input | 26 | Frame number of the first-level table |
| reqValid | input | 1 | Translation request, taken when idle |
| reqVaddr | input | 32 | Virtual address to translate |
| reqAccess | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| busy | output | 1 | Walk in progress |
| memReqValid | output | 1 | Memory word read strobe |
| memReqAddr | output | 38 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Page table entry read from memory |
| doneValid | output | 1 | One-cycle pulse: translation succeeded |
| donePaddr | output | 38 | Physical address, valid with doneValid |
| faultValid | output | 1 | One-cycle pulse: page fault |

## Verification
The bench sweeps first-level indices at both ends of the range against a spread of second-level indices and all four access codes. The table contents come from formulas, so every flag combination appears as a leaf. That sweep separates a correct flag pick from a swapped bit, and a correct index split from a shifted one. Every fourth first-level entry has cleared permission flags but set reserved bits. This shows whether the short fault path fires and whether the reserved bits are wrongly treated as valid. The response delay varies from walk to walk. Some walks also carry stray requests and unprivileged root writes, and the bench checks that these leave addresses and results unchanged.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W    = 32;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 10;
  localparam int FLAG_W  = 6;
  localparam int FRAME_W = 26;
  localparam int PTE_W   = FRAME_W + FLAG_W;
  localparam int PA_W    = FRAME_W + OFF_W;
  localparam int ENT_SH  = OFF_W - IDX_W;
  localparam int RD_BIT  = 0;
  localparam int WR_BIT  = 1;
  localparam int EX_BIT  = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ_L1, ST_WAIT_L1, ST_READ_L2, ST_WAIT_L2, ST_DONE, ST_FAULT
  } walkState_t;

  typedef enum logic [1:0] {
    ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_EXEC = 2'd2, ACC_RSVD = 2'd3
  } access_t;

  typedef struct packed {
    logic captureReq;
    logic captureL1;
    logic captureLeaf;
    logic selLeafTable;
  } walkStrobe_t;
endpackage

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               privMode,
  input  logic               rootWrEn,
  input  logic [FRAME_W-1:0] rootWrData,
  input  logic [VA_W-1:0]    reqVaddr,
  input  logic [1:0]         reqAccess,
  input  logic [PTE_W-1:0]   memRspData,
  input  walkStrobe_t        strb,
  output logic [PA_W-1:0]    memReqAddr,
  output logic [PA_W-1:0]    donePaddr,
  output logic               l1Invalid,
  output logic               leafPermOk
);
  logic [FRAME_W-1:0] rootFrame;
  logic [VA_W-1:0]    vaddrQ;
  logic [1:0]         accessQ;
  logic [FRAME_W-1:0] l1Frame;
  logic [FRAME_W-1:0] leafFrame;
  logic [IDX_W-1:0]   l1Index;
  logic [IDX_W-1:0]   l2Index;
  logic               unusedRsvdFlags;

  assign l1Index = vaddrQ[VA_W-1 -: IDX_W];
  assign l2Index = vaddrQ[OFF_W +: IDX_W];
  assign unusedRsvdFlags = ^memRspData[FLAG_W-1:EX_BIT+1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rootFrame <= '0;
      vaddrQ    <= '0;
      accessQ   <= '0;
      l1Frame   <= '0;
      leafFrame <= '0;
    end else begin
      if (privMode && rootWrEn) rootFrame <= rootWrData;
      if (strb.captureReq) begin
        vaddrQ  <= reqVaddr;
        accessQ <= reqAccess;
      end
      if (strb.captureL1)   l1Frame   <= memRspData[PTE_W-1:FLAG_W];
      if (strb.captureLeaf) leafFrame <= memRspData[PTE_W-1:FLAG_W];
    end
  end

  always_comb begin
    if (strb.selLeafTable) memReqAddr = {l1Frame, l2Index, {ENT_SH{1'b0}}};
    else                   memReqAddr = {rootFrame, l1Index, {ENT_SH{1'b0}}};
  end

  assign l1Invalid = (memRspData[EX_BIT:RD_BIT] == '0);

  always_comb begin
    case (accessQ)
      ACC_READ:  leafPermOk = memRspData[RD_BIT];
      ACC_WRITE: leafPermOk = memRspData[WR_BIT];
      ACC_EXEC:  leafPermOk = memRspData[EX_BIT];
      default:   leafPermOk = 1'b0;
    endcase
  end

  assign donePaddr = {leafFrame, vaddrQ[OFF_W-1:0]};

  // R9: the root register changes only through a privileged write
  a_r9_root_guarded: assert property (@(posedge clk) disable iff (!rstN)
    !(privMode && rootWrEn) |=> $stable(rootFrame));

  // R8: the captured request holds while no new request is taken
  a_r8_request_held: assert property (@(posedge clk) disable iff (!rstN)
    !strb.captureReq |=> $stable(vaddrQ) && $stable(accessQ));
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRspValid,
  input  logic        l1Invalid,
  input  logic        leafPermOk,
  output walkStrobe_t strb,
  output logic        memReqValid,
  output logic        doneValid,
  output logic        faultValid,
  output logic        busy
);
  walkState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:    if (reqValid) stateNext = ST_READ_L1;
      ST_READ_L1: stateNext = ST_WAIT_L1;
      ST_WAIT_L1: if (memRspValid) stateNext = l1Invalid ? ST_FAULT : ST_READ_L2;
      ST_READ_L2: stateNext = ST_WAIT_L2;
      ST_WAIT_L2: if (memRspValid) stateNext = leafPermOk ? ST_DONE : ST_FAULT;
      ST_DONE:    stateNext = ST_IDLE;
      ST_FAULT:   stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.captureReq   = (state == ST_IDLE) && reqValid;
    strb.captureL1    = (state == ST_WAIT_L1) && memRspValid;
    strb.captureLeaf  = (state == ST_WAIT_L2) && memRspValid;
    strb.selLeafTable = (state == ST_READ_L2) || (state == ST_WAIT_L2);
  end

  assign memReqValid = (state == ST_READ_L1) || (state == ST_READ_L2);
  assign doneValid   = (state == ST_DONE);
  assign faultValid  = (state == ST_FAULT);
  assign busy        = (state != ST_IDLE);

  // R2 / R4: each read strobe lasts one cycle
  a_r2_read_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  // R7: result pulses are single-cycle, exclusive and followed by idle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid && !faultValid && !busy);
  a_r7_fault_single: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> !faultValid && !doneValid && !busy);
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(doneValid && faultValid));

  // R3: an empty first-level entry faults at once
  a_r3_l1_fault: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_L1 && memRspValid && l1Invalid) |=> faultValid);

  // R5: a missing leaf permission faults
  a_r5_leaf_fault: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_L2 && memRspValid && !leafPermOk) |=> faultValid);

  // R10: waiting states hold until the response arrives
  a_r10_wait_holds: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_WAIT_L1 || state == ST_WAIT_L2) && !memRspValid) |=> $stable(state));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               privMode,
  input  logic               rootWrEn,
  input  logic [FRAME_W-1:0] rootWrData,
  input  logic               reqValid,
  input  logic [VA_W-1:0]    reqVaddr,
  input  logic [1:0]         reqAccess,
  output logic               busy,
  output logic               memReqValid,
  output logic [PA_W-1:0]    memReqAddr,
  input  logic               memRspValid,
  input  logic [PTE_W-1:0]   memRspData,
  output logic               doneValid,
  output logic [PA_W-1:0]    donePaddr,
  output logic               faultValid
);
  walkStrobe_t strb;
  logic        l1Invalid;
  logic        leafPermOk;

  ptw_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memRspValid (memRspValid),
    .l1Invalid   (l1Invalid),
    .leafPermOk  (leafPermOk),
    .strb        (strb),
    .memReqValid (memReqValid),
    .doneValid   (doneValid),
    .faultValid  (faultValid),
    .busy        (busy)
  );

  ptw_datapath dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .privMode   (privMode),
    .rootWrEn   (rootWrEn),
    .rootWrData (rootWrData),
    .reqVaddr   (reqVaddr),
    .reqAccess  (reqAccess),
    .memRspData (memRspData),
    .strb       (strb),
    .memReqAddr (memReqAddr),
    .donePaddr  (donePaddr),
    .l1Invalid  (l1Invalid),
    .leafPermOk (leafPermOk)
  );
endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  import ptw_pkg::*;

  localparam logic [25:0] ROOT_A = 26'h12345;
  localparam logic [25:0] ROOT_B = 26'h0ABCD;
  localparam int L2_BASE = 'h100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        privMode = 1'b0, rootWrEn = 1'b0;
  logic [25:0] rootWrData = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqAccess = '0;
  logic        busy, memReqValid, doneValid, faultValid;
  logic [37:0] memReqAddr, donePaddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  int checks = 0;
  int errors = 0;
  logic [25:0] expRoot = ROOT_A;

  always #5 clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rstN(rstN), .privMode(privMode), .rootWrEn(rootWrEn),
    .rootWrData(rootWrData), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqAccess(reqAccess), .busy(busy), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .doneValid(doneValid), .donePaddr(donePaddr), .faultValid(faultValid)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // First-level entries: every fourth index has rwx clear but reserved bits set.
  function automatic logic [31:0] l1Entry(int i);
    logic [25:0] fr = 26'(L2_BASE + i);
    if (i % 4 == 3) return {fr, 6'b111000};
    return {fr, 3'b000, 3'((i % 7) + 1)};
  endfunction

  function automatic logic [25:0] leafFrameOf(int i, int j);
    return 26'h200000 ^ {6'b0, 10'(i), 10'(j)};
  endfunction

  function automatic logic [31:0] leafEntry(int i, int j);
    return {leafFrameOf(i, j), 3'b000, 3'((i + j) % 8)};
  endfunction

  function automatic logic [31:0] memFunc(logic [37:0] a);
    logic [25:0] fr = a[37:12];
    int idx = int'(a[11:2]);
    int fi = int'(fr);
    if (fr == ROOT_A || fr == ROOT_B) return l1Entry(idx);
    if (fi >= L2_BASE && fi < L2_BASE + 1024) return leafEntry(fi - L2_BASE, idx);
    return 32'hDEAD_BEEF;
  endfunction

  task automatic walk(logic [31:0] va, logic [1:0] acc, int lat, bit stray);
    int i = int'(va[31:22]);
    int j = int'(va[21:12]);
    bit l1Bad = (i % 4 == 3);
    logic [2:0] fl = 3'((i + j) % 8);
    bit permit = !l1Bad && (acc != 2'd3) && fl[acc];
    int nReads = 0;
    int cyc = 0;
    bit fin = 0;
    bit gotDone = 0, gotFault = 0;
    logic [37:0] gotPa = '0;
    logic [37:0] rdAddr;
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqAccess = acc;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R7", "busy after accept", 64'(busy), 64'(1));
    while (!fin && cyc < 100) begin
      if (memReqValid) begin
        nReads++;
        rdAddr = memReqAddr;
        if (nReads == 1)
          chk("R2", "first-level address", 64'(rdAddr), 64'({expRoot, va[31:22], 2'b00}));
        else
          chk("R4", "second-level address", 64'(rdAddr),
              64'({l1Entry(i)[31:6], va[21:12], 2'b00}));
        repeat (lat) begin
          @(negedge clk);
          cyc++;
          chk("R10", "no read while waiting", 64'(memReqValid), 64'(0));
          reqValid = stray; reqVaddr = ~va; reqAccess = 2'd0;
        end
        reqValid = 1'b0;
        memRspValid = 1'b1; memRspData = memFunc(rdAddr);
        @(negedge clk);
        memRspValid = 1'b0; memRspData = 32'hFFFF_FFFF;
      end else if (doneValid || faultValid) begin
        fin = 1; gotDone = doneValid; gotFault = faultValid; gotPa = donePaddr;
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    if (!fin) begin
      checks++; errors++;
      $display("FAIL R10 walk hung: actual no result expected result for va %0h", va);
      return;
    end
    chk(l1Bad ? "R3" : "R5", "fault flag", 64'(gotFault), 64'(!permit));
    chk("R7", "done flag", 64'(gotDone), 64'(permit));
    chk("R3", "read count", 64'(nReads), 64'(l1Bad ? 1 : 2));
    if (permit)
      chk("R6", "physical address", 64'(gotPa), 64'({leafFrameOf(i, j), va[11:0]}));
    @(negedge clk);
    chk("R7", "pulse ends", 64'({doneValid, faultValid, busy}), 64'(0));
    if (stray) begin
      @(negedge clk);
      chk("R8", "no walk from stray request", 64'({busy, memReqValid}), 64'(0));
    end
  endtask

  task automatic writeRoot(logic priv, logic [25:0] val);
    @(negedge clk);
    privMode = priv; rootWrEn = 1'b1; rootWrData = val;
    @(negedge clk);
    privMode = 1'b0; rootWrEn = 1'b0;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "reset outputs", 64'({busy, memReqValid, doneValid, faultValid}), 64'(0));

    writeRoot(1'b1, ROOT_A);
    writeRoot(1'b0, ROOT_B);   // R9: unprivileged write must be ignored
    expRoot = ROOT_A;
    walk({10'd1, 10'd2, 12'h345}, 2'd0, 1, 1'b0);

    for (int ii = 0; ii < 12; ii++) begin
      for (int jj = 0; jj < 8; jj++) begin
        for (int a = 0; a < 4; a++) begin
          int i = (ii < 8) ? ii : 1012 + ii;
          int j = (jj < 6) ? jj : ((jj == 6) ? 512 : 1023);
          logic [11:0] off = (a == 3) ? 12'hFFF : 12'((i * 37 + j * 11 + a) & 'hFFF);
          walk({10'(i), 10'(j), off}, 2'(a), 1 + ((i + j + a) % 4), ((i + a) % 3) == 0);
        end
      end
    end

    writeRoot(1'b1, ROOT_B);   // R9: privileged write takes effect
    expRoot = ROOT_B;
    walk({10'd5, 10'd6, 12'h001}, 2'd2, 7, 1'b1);
    walk({10'd3, 10'd0, 12'h000}, 2'd1, 2, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule